// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block is the buffering and control section of one channel of a 16550-class serial port. It holds a 16-byte receive queue, which the receive shifter fills and the host drains, and a 16-byte transmit queue, which the host fills and the transmit shifter drains. It also holds the write-only FIFO control byte, which sets the following:
- whether the queues are active;
- whether either queue is flushed;
- whether the ready strobes follow DMA rules;
- the receive fill level that raises an interrupt.

When the queues are off, each direction holds a single byte, as a classic holding register does. Flush requests act on the queue pointers and counts at the edge where the control write lands. They are never stored, so the next write or push behaves normally. The shifters, baud clocking, line status and modem lines live outside this block.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, both levels are 0, `rx_irq` is 0, `rxrdy_n` is 1, `txrdy_n` is 0, and the queues are off, so each has a capacity of one byte.
- R2: Control bit 0 turns the queues on when 1, giving a capacity of 16 bytes per direction; when 0 the capacity is 1. A push into a queue already at capacity is dropped and leaves its level and contents unchanged, even if a pop happens in the same cycle.
- R3: A control write whose bit 0 differs from the current on/off state empties both queues at that write's clock edge.
- R4: A control write with bits 0 and 1 both set empties the receive queue at that edge and leaves the transmit queue alone. The request is not retained, so pushes in later cycles count up from 0.
- R5: A control write with bits 0 and 2 both set empties the transmit queue at that edge and leaves the receive queue alone. This request is not retained either.
- R6: In a control write with bit 0 clear, bits 1 and 2 have no effect, and bits 5:4 never have an effect.
- R7: Control bits 7:6, taken when bit 0 is set, choose the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. `rx_irq` is high whenever the receive level is at or above the threshold. While the queues are off, the threshold is 1.
- R8: `rx_irq` drops in the cycle after a host read brings the receive level below the threshold.
- R9: In normal mode (control bit 3 clear, or queues off), `rxrdy_n` is low when the receive level is at least 1, and `txrdy_n` is low when the transmit queue is empty.
- R10: In DMA mode (control bit 3 set together with bit 0), `rxrdy_n` is low when the receive level is at or above the threshold, and `txrdy_n` is low while the transmit level is below 16.
- R11: Bytes leave each queue in arrival order. `host_rdata` and `tx_pop_data` show the oldest byte without waiting for a clock edge. A pop from an empty queue is ignored.
- R12: A push and a pop on the same queue in one cycle, when the queue is neither empty nor full, both take effect and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the FIFO control byte |
| cfg_wdata | input | 8 | Control byte being written |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Byte from the receive shifter |
| host_rd | input | 1 | Host takes the oldest received byte |
| host_rdata | output | 8 | Oldest byte in the receive queue |
| host_wr | input | 1 | Host queues a byte for transmission |
| host_wdata | input | 8 | Byte from the host |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| tx_pop_data | output | 8 | Oldest byte in the transmit queue |
| rx_level | output | 5 | Receive queue occupancy |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_irq | output | 1 | Receive threshold reached |
| rxrdy_n | output | 1 | Active-low receive ready strobe |
| txrdy_n | output | 1 | Active-low transmit ready strobe |

## Verification
The hardest case to reach from the ports is a full queue that receives one more push while every combination of threshold code and DMA setting is in force. Reaching it needs sixteen accepted pushes after a control write that is itself a flush. The bench sweeps all eight threshold and mode settings. For each setting it first issues a flushing control write, then pushes 17 bytes and drains 17 bytes in each direction, so every fill level is visited on the way up and on the way down. A second awkward case is a byte sitting in the one-byte holding register while the queues are off. The bench parks a byte there and then issues flush-bit writes with bit 0 clear, showing at the level outputs that the byte survives.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef struct packed {
        logic       en;
        logic       dma;
        logic [1:0] trig;
    } ufc_cfg_t;

    localparam logic [4:0] TRIG_A = 5'd1;
    localparam logic [4:0] TRIG_B = 5'd4;
    localparam logic [4:0] TRIG_C = 5'd8;
    localparam logic [4:0] TRIG_D = 5'd14;

    // non-linear threshold code
    function automatic logic [4:0] ufc_trig_level(input logic [1:0] code);
        logic [4:0] lvl;
        case (code)
            2'b00:   lvl = TRIG_A;
            2'b01:   lvl = TRIG_B;
            2'b10:   lvl = TRIG_C;
            default: lvl = TRIG_D;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ufc_cfg_reg.sv
module ufc_cfg_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ufc_cfg_t   cfg,
    output logic       rx_clr,
    output logic       tx_clr
);

    ufc_cfg_t cfg_d, cfg_q;
    logic     unused_rsvd;

    assign unused_rsvd = ^wdata[5:4];

    always_comb begin
        cfg_d  = cfg_q;
        rx_clr = 1'b0;
        tx_clr = 1'b0;
        if (we) begin
            cfg_d.en = wdata[0];
            if (wdata[0] != cfg_q.en) begin
                rx_clr = 1'b1;
                tx_clr = 1'b1;
            end
            if (wdata[0]) begin
                cfg_d.dma  = wdata[3];
                cfg_d.trig = wdata[7:6];
                if (wdata[1]) rx_clr = 1'b1;
                if (wdata[2]) tx_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       cap_one,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [CNT_W-1:0] limit;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign limit = cap_one ? CNT_W'(1) : CNT_W'(DEPTH);

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt < limit);
        pop_ok  = pop && (st_q.cnt != '0);
        if (clr) begin
            st_d    = '0;
            push_ok = 1'b0;
            pop_ok  = 1'b0;
        end else begin
            if (push_ok) st_d.wp = adv(st_q.wp);
            if (pop_ok)  st_d.rp = adv(st_q.rp);
            st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= din;
    end

    assign dout  = mem[st_q.rp];
    assign level = st_q.cnt;

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_push_data,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_pop_data,
    output logic [CNT_W-1:0] rx_level,
    output logic [CNT_W-1:0] tx_level,
    output logic             rx_irq,
    output logic             rxrdy_n,
    output logic             txrdy_n
);

    ufc_cfg_t         cfg;
    logic             rx_clr, tx_clr;
    logic             fifo_en, dma_on;
    logic [CNT_W-1:0] rx_thr, tx_cap;
    logic             rx_hit;

    ufc_cfg_reg i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .cfg    (cfg),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .cap_one (!fifo_en),
        .push    (rx_push),
        .din     (rx_push_data),
        .pop     (host_rd),
        .dout    (host_rdata),
        .level   (rx_level)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .cap_one (!fifo_en),
        .push    (host_wr),
        .din     (host_wdata),
        .pop     (tx_pop),
        .dout    (tx_pop_data),
        .level   (tx_level)
    );

    assign fifo_en = cfg.en;
    assign dma_on  = cfg.en & cfg.dma;
    assign rx_thr  = fifo_en ? CNT_W'(ufc_trig_level(cfg.trig)) : CNT_W'(1);
    assign tx_cap  = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign rx_hit  = (rx_level >= rx_thr);

    assign rx_irq  = rx_hit;
    assign rxrdy_n = dma_on ? !rx_hit : (rx_level == '0);
    assign txrdy_n = dma_on ? !(tx_level < tx_cap) : (tx_level != '0);

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic             host_rd,
    input logic             fifo_en,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level,
    input logic             rx_irq,
    input logic             txrdy_n
);

    AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= CNT_W'(DEPTH)); // R2

    AST_OFF_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_level <= CNT_W'(1) && tx_level <= CNT_W'(1))); // R2

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == CNT_W'(DEPTH) && !host_rd && !cfg_we) |=> rx_level == CNT_W'(DEPTH)); // R2

    AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] != fifo_en) |=> (rx_level == '0 && tx_level == '0)); // R3

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> rx_level == '0); // R4

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> tx_level == '0); // R5

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_level != '0); // R7

    AST_TXRDY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level == '0 |-> !txrdy_n); // R9

endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH)) i_ufc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .host_rd   (host_rd),
    .fifo_en   (fifo_en),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .rx_irq    (rx_irq),
    .txrdy_n   (txrdy_n)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_pop_data;
    logic [4:0] rx_level, tx_level;
    logic       rx_irq, rxrdy_n, txrdy_n;

    int total = 0;
    int bad = 0;

    // reference model
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit         m_en = 0;
    bit         m_dma = 0;
    int         m_trig = 0;

    always #4 clk = ~clk;

    uart_fifo_ctl i_uart_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_level(rx_level),
        .tx_level(tx_level), .rx_irq(rx_irq), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    function automatic int thr();
        int t;
        case (m_trig)
            0: t = 1;
            1: t = 4;
            2: t = 8;
            default: t = 14;
        endcase
        return m_en ? t : 1;
    endfunction

    function automatic int cap();
        return m_en ? 16 : 1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int rn = rxq.size();
        int tn = txq.size();
        bit dm = m_en && m_dma;
        chk(req, "rx_level", int'(rx_level), rn);
        chk(req, "tx_level", int'(tx_level), tn);
        chk(req, "rx_irq", int'(rx_irq), int'(rn >= thr()));
        chk(req, "rxrdy_n", int'(rxrdy_n), dm ? int'(!(rn >= thr())) : int'(rn == 0));
        chk(req, "txrdy_n", int'(txrdy_n), dm ? int'(!(tn < cap())) : int'(tn != 0));
    endtask

    // one cycle of queue traffic; model updated from pre-edge state
    task automatic step(input bit psh, input logic [7:0] pd, input bit rd,
                        input bit wr, input logic [7:0] wd, input bit tp,
                        input string req);
        int rn = rxq.size();
        int tn = txq.size();
        if (rd && rn > 0) chk(req, "host_rdata", int'(host_rdata), int'(rxq[0]));
        if (tp && tn > 0) chk(req, "tx_pop_data", int'(tx_pop_data), int'(txq[0]));
        rx_push = psh; rx_push_data = pd; host_rd = rd;
        host_wr = wr; host_wdata = wd; tx_pop = tp;
        @(negedge clk);
        rx_push = 0; host_rd = 0; host_wr = 0; tx_pop = 0;
        if (rd && rn > 0) void'(rxq.pop_front());
        if (psh && rn < cap()) rxq.push_back(pd);
        if (tp && tn > 0) void'(txq.pop_front());
        if (wr && tn < cap()) txq.push_back(wd);
        check_all(req);
    endtask

    task automatic cfg_write(input logic [7:0] v, input string req);
        if (v[0] != m_en) begin rxq.delete(); txq.delete(); end
        m_en = v[0];
        if (v[0]) begin
            m_dma  = v[3];
            m_trig = int'(v[7:6]);
            if (v[1]) rxq.delete();
            if (v[2]) txq.delete();
        end
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        check_all(req);
    endtask

    task automatic finish_report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: act=timeout exp=done");
        finish_report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // queues off: single holding byte per direction
        step(1, 8'hA5, 0, 1, 8'h3C, 0, "R2");
        step(1, 8'h5A, 0, 1, 8'hC3, 0, "R2");
        chk("R2", "held byte", int'(host_rdata), 32'hA5);

        // flush bits without bit 0: no effect on held bytes
        cfg_write(8'h02, "R6");
        cfg_write(8'h06, "R6");
        chk("R6", "rx kept", int'(rx_level), 1);
        chk("R6", "tx kept", int'(tx_level), 1);

        // turning queues on flushes both
        cfg_write(8'h31, "R3");
        chk("R3", "rx flushed", int'(rx_level), 0);

        // sweep every threshold code and both modes
        for (int tc = 0; tc < 4; tc++) begin
            for (int dm = 0; dm < 2; dm++) begin
                logic [7:0] v;
                v = {2'(tc), 2'(dm * 3), 1'(dm), 3'b111};
                cfg_write(v, "R4/R5");
                for (int k = 0; k < 17; k++)
                    step(1, 8'(k * 13 + tc * 7 + dm + 1), 0,
                         1, 8'(k * 11 + tc), 0, dm ? "R7/R10" : "R7/R9");
                for (int k = 0; k < 17; k++)
                    step(0, 8'h00, 1, 0, 8'h00, 1, "R8/R11");
            end
        end

        // simultaneous push and pop keep the level
        cfg_write(8'h07, "R4");
        for (int k = 0; k < 3; k++) step(1, 8'(k + 40), 0, 1, 8'(k + 60), 0, "R11");
        step(1, 8'd77, 1, 1, 8'd88, 1, "R12");
        chk("R12", "rx level", int'(rx_level), 3);
        chk("R12", "tx level", int'(tx_level), 3);

        // receive-only flush, self-clearing
        step(1, 8'd91, 0, 1, 8'd92, 0, "R11");
        cfg_write(8'h03, "R4");
        chk("R4", "tx untouched", int'(tx_level), 4);
        step(1, 8'd93, 0, 0, 8'd0, 0, "R4");
        chk("R4", "push after flush", int'(rx_level), 1);

        // transmit-only flush
        cfg_write(8'h05, "R5");
        chk("R5", "rx untouched", int'(rx_level), 1);
        step(0, 8'd0, 0, 1, 8'd94, 0, "R5");
        chk("R5", "write after flush", int'(tx_level), 1);

        // pop from empty ignored
        step(0, 8'd0, 1, 0, 8'd0, 0, "R11");
        step(0, 8'd0, 1, 0, 8'd0, 1, "R11");

        // turning queues off flushes
        step(1, 8'd95, 0, 0, 8'd0, 0, "R2");
        cfg_write(8'h00, "R3");

        finish_report();
    end

endmodule